// File: doc/BRIEF.md
# One-Time-Programmable Fuse Command Sequencer

This block runs commands against a one-time-programmable fuse array of 96 words of 32 bits. The array sits inside the block as a bit-settable memory. Software writes four registers. The first asks for fuse power. The second holds a program value. The third holds a sticky global program lock. The fourth issues a command. The block then reports busy, program-fail, power-acknowledge and a shadow word back on plain output pins.

Every command needs the array to be powered. A power request rises through a configuration bit, and the acknowledge follows it a fixed number of cycles later, in both directions. There are three commands. A read copies one fuse word into the shadow output. A program ORs the write-data value into one fuse word. A lock burns permanent write-protect bits into a small lock area using a packed encoding. Per-word input vectors supply the shadow-read locks and the sticky program locks.

Top module: `otp_fuse_seq`

## Requirements
- R1: While reset is held and just after it, `pwr_ack`, `busy` and `prog_fail` are 0 and `shadow_data` is 0.
- R2: A write to register 0 puts bit 0 into the power request. `pwr_ack` takes the new request value exactly PWR_DLY cycles after the write edge, both when powering up and when powering down.
- R3: If a command is written to register 1 while `pwr_ack` is 0, it does not run. `prog_fail` goes to 1 on the write edge, `busy` stays 0, and no fuse word changes.
- R4: A command with control bit 8 clear is a read of the word in bits 6:0. `busy` is high for RD_CYC cycles. When `busy` falls, `shadow_data` holds that fuse word. `shadow_data` changes at no other time.
- R5: A read of word n while `rd_lock[n]` is 1 loads 0 into `shadow_data`.
- R6: A command with bit 8 set and bit 9 clear programs word n. `busy` is high for PG_CYC cycles, and the fuse word becomes its old value ORed with the value last written to register 2. A 1 bit never returns to 0.
- R7: After bit 4 has been written as 1 to register 3 (sticky until reset), program commands run for their full busy time but change no fuse and leave `prog_fail` at 0.
- R8: A program of word n while `pg_lock[n]` is 1 runs for its full busy time, changes no fuse and leaves `prog_fail` at 0.
- R9: A command with bits 8 and 9 both set ORs bits 15:0 of register 2 into lock row `idx` (rows 0 to 7), with busy for PG_CYC cycles. Word n < 32 is locked by either bit (2n mod 16) or bit (2n mod 16)+1 of row n/8. Word n >= 32 is locked by bit (n mod 16) of row 4+(n-32)/16. A program of a locked word leaves the fuse unchanged and sets `prog_fail` when `busy` falls. This check takes priority over R7 and R8.
- R10: A read or program with index above 95, or a lock with row index above 7, is rejected. `prog_fail` goes to 1 and `busy` stays 0.
- R11: While `busy` is 1, writes to register 1 and register 2 have no effect.
- R12: Every accepted command clears `prog_fail` on its start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 power, 1 command, 2 write data, 3 global lock |
| reg_wdata | input | 32 | Register write value |
| rd_lock | input | 96 | Per-word shadow-read lock |
| pg_lock | input | 96 | Per-word sticky program lock |
| pwr_ack | output | 1 | Fuse array powered |
| busy | output | 1 | Command in progress |
| prog_fail | output | 1 | Last command rejected or failed |
| shadow_data | output | 32 | Word loaded by the last read |

## Verification
The power acknowledge is due PWR_DLY edges after the configuration write edge. An accepted command holds `busy` for exactly RD_CYC or PG_CYC cycles from its write edge. Its shadow and fail results appear on the edge where `busy` falls. A rejected command shows `prog_fail` high with `busy` low on the write edge itself. The bench samples at falling edges and counts the samples with `busy` or the old acknowledge value against those counts. A scoreboard monitor compares the queued shadow and fail values only at the falling edge where `busy` is first seen low.

// File: rtl/otp_fuse_seq.sv
module otp_fuse_seq #(
  parameter int WORDS     = 96,
  parameter int LOW_WORDS = 32,
  parameter int PWR_DLY   = 4,
  parameter int RD_CYC    = 3,
  parameter int PG_CYC    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic [WORDS-1:0] rd_lock,
  input  logic [WORDS-1:0] pg_lock,
  output logic             pwr_ack,
  output logic             busy,
  output logic             prog_fail,
  output logic [31:0]      shadow_data
);
  localparam int IDXW      = $clog2(WORDS);
  localparam int LOCK_ROWS = LOW_WORDS / 8 + (WORDS - LOW_WORDS + 15) / 16;
  localparam int LRW       = $clog2(LOCK_ROWS);
  localparam int MAXC      = (PG_CYC > RD_CYC) ? PG_CYC : RD_CYC;
  localparam int CW        = $clog2(MAXC + 1);
  localparam int PW        = $clog2(PWR_DLY + 1);

  localparam logic [IDXW-1:0] WORDS_I  = IDXW'(WORDS);
  localparam logic [IDXW-1:0] LOW_I    = IDXW'(LOW_WORDS);
  localparam logic [IDXW-1:0] ROWS_I   = IDXW'(LOCK_ROWS);
  localparam logic [LRW-1:0]  LOWROW_I = LRW'(LOW_WORDS / 8);

  localparam logic [1:0] A_CFG = 2'd0, A_CTRL = 2'd1, A_WDATA = 2'd2, A_GLOCK = 2'd3;
  localparam logic [1:0] OP_RD = 2'd0, OP_PG = 2'd1, OP_LK = 2'd2;

  logic            pwr_req_q, pwr_ack_q;
  logic [PW-1:0]   pcnt_q;
  logic [31:0]     wdata_q;
  logic            glock_q;
  logic            busy_q, fail_q;
  logic [CW-1:0]   bcnt_q;
  logic [1:0]      op_q;
  logic [IDXW-1:0] idx_q;
  logic [31:0]     shadow_q;
  logic [31:0]     fuse_q [WORDS];
  logic [15:0]     lock_q [LOCK_ROWS];

  logic            wr_ctrl, cmd_lk, idx_ok, done;
  logic [IDXW-1:0] cmd_idx;
  logic [LRW-1:0]  lrow;
  logic            plocked;

  assign wr_ctrl = reg_we && reg_addr == A_CTRL && !busy_q;
  assign cmd_idx = reg_wdata[IDXW-1:0];
  assign cmd_lk  = reg_wdata[8] & reg_wdata[9];
  assign idx_ok  = cmd_lk ? (cmd_idx < ROWS_I) : (cmd_idx < WORDS_I);
  assign done    = busy_q && bcnt_q == CW'(1);

  always_comb begin
    if (idx_q < LOW_I) begin
      lrow    = LRW'(idx_q >> 3);
      plocked = lock_q[lrow][{idx_q[2:0], 1'b0}] | lock_q[lrow][{idx_q[2:0], 1'b1}];
    end else begin
      lrow    = LOWROW_I + LRW'((idx_q - LOW_I) >> 4);
      plocked = lock_q[lrow][idx_q[3:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_req_q <= 1'b0;
      pwr_ack_q <= 1'b0;
      pcnt_q    <= '0;
    end else begin
      if (reg_we && reg_addr == A_CFG) pwr_req_q <= reg_wdata[0];
      if (pwr_req_q == pwr_ack_q) begin
        pcnt_q <= '0;
      end else if (pcnt_q == PW'(PWR_DLY - 1)) begin
        pwr_ack_q <= pwr_req_q;
        pcnt_q    <= '0;
      end else begin
        pcnt_q <= pcnt_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
      glock_q <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_WDATA && !busy_q) wdata_q <= reg_wdata;
      if (reg_we && reg_addr == A_GLOCK) glock_q <= glock_q | reg_wdata[4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      fail_q   <= 1'b0;
      bcnt_q   <= '0;
      op_q     <= OP_RD;
      idx_q    <= '0;
      shadow_q <= '0;
      for (int i = 0; i < WORDS; i++) fuse_q[i] <= '0;
      for (int r = 0; r < LOCK_ROWS; r++) lock_q[r] <= '0;
    end else if (wr_ctrl) begin
      if (!pwr_ack_q || !idx_ok) begin
        fail_q <= 1'b1;
      end else begin
        fail_q <= 1'b0;
        busy_q <= 1'b1;
        idx_q  <= cmd_idx;
        op_q   <= cmd_lk ? OP_LK : (reg_wdata[8] ? OP_PG : OP_RD);
        bcnt_q <= reg_wdata[8] ? CW'(PG_CYC) : CW'(RD_CYC);
      end
    end else if (busy_q) begin
      bcnt_q <= bcnt_q - CW'(1);
      if (done) begin
        busy_q <= 1'b0;
        case (op_q)
          OP_RD: shadow_q <= rd_lock[idx_q] ? '0 : fuse_q[idx_q];
          OP_PG: begin
            if (plocked) fail_q <= 1'b1;
            else if (!glock_q && !pg_lock[idx_q]) fuse_q[idx_q] <= fuse_q[idx_q] | wdata_q;
          end
          default: lock_q[idx_q[LRW-1:0]] <= lock_q[idx_q[LRW-1:0]] | wdata_q[15:0];
        endcase
      end
    end
  end

  assign pwr_ack     = pwr_ack_q;
  assign busy        = busy_q;
  assign prog_fail   = fail_q;
  assign shadow_data = shadow_q;
endmodule

module otp_fuse_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [1:0]  reg_addr,
  input logic        pwr_req,
  input logic        pwr_ack,
  input logic        busy,
  input logic        prog_fail,
  input logic [31:0] shadow_data
);
  assert_nopwr_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd1 && !busy && !pwr_ack) |=> (prog_fail && !busy));

  assert_ack_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_ack) |-> $past(pwr_req));

  assert_ack_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_ack) |-> !$past(pwr_req));

  assert_busy_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we && reg_addr == 2'd1 && pwr_ack));

  assert_fail_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !prog_fail);

  assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(shadow_data));
endmodule

bind otp_fuse_seq otp_fuse_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .pwr_req(pwr_req_q), .pwr_ack(pwr_ack), .busy(busy),
  .prog_fail(prog_fail), .shadow_data(shadow_data)
);

// File: tb/otp_fuse_seq_tb.sv
module otp_fuse_seq_tb;
  localparam int WORDS = 96, PWR_DLY = 4, RD_CYC = 3, PG_CYC = 8;
  localparam logic [1:0] A_CFG = 2'd0, A_CTRL = 2'd1, A_WDATA = 2'd2, A_GLOCK = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [WORDS-1:0] rd_lock = '0, pg_lock = '0;
  logic pwr_ack, busy, prog_fail;
  logic [31:0] shadow_data;

  always #5 clk = ~clk;

  otp_fuse_seq #(.WORDS(WORDS), .LOW_WORDS(32), .PWR_DLY(PWR_DLY), .RD_CYC(RD_CYC), .PG_CYC(PG_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_lock(rd_lock), .pg_lock(pg_lock), .pwr_ack(pwr_ack), .busy(busy),
    .prog_fail(prog_fail), .shadow_data(shadow_data));

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] m_fuse [WORDS];
  logic [15:0] m_lock [8];
  logic [31:0] m_shadow = '0;
  bit m_glock = 0;

  logic [31:0] q_sh[$];
  logic        q_f[$];
  string       q_tag[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic busy_prev = 1'b0;
  always @(negedge clk) begin
    if (busy_prev && !busy) begin
      if (q_sh.size() == 0) begin
        check(0, "R4 unexpected completion", 32'(busy), 32'd0);
      end else begin
        logic [31:0] es; logic ef; string t;
        es = q_sh.pop_front(); ef = q_f.pop_front(); t = q_tag.pop_front();
        check(shadow_data == es, t, shadow_data, es);
        check(prog_fail == ef, t, 32'(prog_fail), 32'(ef));
      end
    end
    busy_prev = busy;
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_idle(input int exp_cyc, input string req);
    int c = 0;
    while (busy && c < 1000) begin c++; @(negedge clk); end
    if (exp_cyc > 0) check(c == exp_cyc, req, 32'(c), 32'(exp_cyc));
  endtask

  task automatic cmd(input logic [31:0] ctrl, input int cyc, input logic [31:0] es, input bit ef, input string req);
    if (cyc > 0) begin
      q_sh.push_back(es); q_f.push_back(ef); q_tag.push_back(req);
    end
    wr(A_CTRL, ctrl);
    if (cyc == 0) begin
      check(!busy && prog_fail, req, {30'd0, busy, prog_fail}, 32'h1);
    end else begin
      check(!prog_fail, "R12 fail cleared at start", 32'(prog_fail), 32'd0);
      wait_idle(cyc, req);
    end
  endtask

  function automatic bit m_perm(input int n);
    if (n < 32) return m_lock[n / 8][(2 * n) % 16 +: 2] != 2'b00;
    return m_lock[4 + (n - 32) / 16][n % 16];
  endfunction

  task automatic do_read(input int n, input string req);
    m_shadow = rd_lock[n] ? 32'd0 : m_fuse[n];
    cmd(32'(n), RD_CYC, m_shadow, 1'b0, req);
  endtask

  task automatic do_prog(input int n, input logic [31:0] v, input string req);
    bit ef = 0;
    wr(A_WDATA, v);
    if (m_perm(n)) ef = 1;
    else if (!m_glock && !pg_lock[n]) m_fuse[n] = m_fuse[n] | v;
    cmd(32'h100 | 32'(n), PG_CYC, m_shadow, ef, req);
  endtask

  task automatic do_lock_word(input int n);
    int row; logic [15:0] v;
    if (n < 32) begin row = n / 8; v = 16'h3 << ((2 * n) % 16); end
    else begin row = 4 + (n - 32) / 16; v = 16'h1 << (n % 16); end
    wr(A_WDATA, 32'hFFFF_0000 | 32'(v));
    m_lock[row] = m_lock[row] | v;
    cmd(32'h300 | 32'(row), PG_CYC, m_shadow, 1'b0, "R9 lock command");
  endtask

  task automatic power(input bit on);
    int c = 0;
    wr(A_CFG, 32'(on));
    while (pwr_ack != on && c < 100) begin c++; @(negedge clk); end
    check(c == PWR_DLY, "R2 power ack delay", 32'(c), 32'(PWR_DLY));
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    for (int i = 0; i < WORDS; i++) m_fuse[i] = '0;
    for (int r = 0; r < 8; r++) m_lock[r] = '0;
    repeat (3) @(negedge clk);
    check(!pwr_ack && !busy && !prog_fail && shadow_data == 0, "R1 reset state",
          {shadow_data[28:0], pwr_ack, busy, prog_fail}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!pwr_ack && !busy && !prog_fail && shadow_data == 0, "R1 after reset",
          {shadow_data[28:0], pwr_ack, busy, prog_fail}, 32'd0);

    cmd(32'd4, 0, 0, 1, "R3 read without power");
    wr(A_WDATA, 32'hFFFF_FFFF);
    cmd(32'h101, 0, 0, 1, "R3 program without power");

    power(1);
    do_read(1, "R3 word unchanged after unpowered program");
    do_read(5, "R4 read blank word");
    do_prog(5, 32'hA5A5_0F0F, "R6 program");
    do_read(5, "R6 read programmed word");
    do_prog(5, 32'h0000_F0F0, "R6 program again");
    do_read(5, "R6 OR accumulates");
    check(m_fuse[5] == 32'hA5A5_FFFF, "R6 model value", m_fuse[5], 32'hA5A5_FFFF);

    // R11: writes during busy are dropped
    wr(A_WDATA, 32'h1234_5678);
    q_sh.push_back(m_shadow); q_f.push_back(1'b0); q_tag.push_back("R11 program under test");
    wr(A_CTRL, 32'h10A);
    wr(A_WDATA, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'd11);
    wait_idle(0, "R11");
    m_fuse[10] = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check(!busy && q_sh.size() == 0, "R11 no command from busy write", 32'(q_sh.size()), 32'd0);
    do_read(10, "R11 write data kept");

    rd_lock[5] = 1'b1;
    do_read(5, "R5 read-locked word gives zero");
    rd_lock[5] = 1'b0;
    do_read(5, "R5 unlocked again");

    pg_lock[20] = 1'b1;
    do_prog(20, 32'hDEAD_BEEF, "R8 sticky lock ignores program");
    pg_lock[20] = 1'b0;
    do_read(20, "R8 word untouched");

    do_prog(40, 32'h0000_00F0, "R9 program before lock");
    do_lock_word(3);
    do_lock_word(40);
    do_lock_word(95);
    do_prog(3, 32'h0000_0001, "R9 locked low word fails");
    do_prog(40, 32'hFFFF_0000, "R9 locked high word fails");
    do_prog(95, 32'h8000_0000, "R9 last word locked fails");
    do_prog(2, 32'h0000_0022, "R9 neighbour still programs");
    do_prog(41, 32'h0000_0041, "R9 high neighbour still programs");
    do_read(3, "R9 word 3 unchanged");
    do_read(40, "R9 word 40 unchanged");
    do_read(2, "R9 word 2 programmed");
    do_read(41, "R9 word 41 programmed");

    cmd(32'd96, 0, 0, 1, "R10 read index out of range");
    cmd(32'h300 | 32'd8, 0, 0, 1, "R10 lock row out of range");
    do_read(95, "R12 accepted after reject");

    wr(A_GLOCK, 32'h10);
    m_glock = 1;
    do_prog(7, 32'h7777_7777, "R7 global lock ignores program");
    do_read(7, "R7 word untouched");

    power(0);
    cmd(32'd5, 0, 0, 1, "R3 read after power down");

    repeat (3) @(negedge clk);
    check(q_sh.size() == 0, "R4 all completions seen", 32'(q_sh.size()), 32'd0);
    summary();
  end
endmodule